// File: doc/BRIEF.md
# Six-Step Brushless Motor Commutation Controller

This block turns three digitized rotor-position sensor phases into six gate enables, a high-side and a low-side enable for each of three motor phases. In every valid rotor position one phase is sourced through its high-side switch and a different phase is sunk through its low-side switch. The third phase stays undriven. The high-side switch stays fully on for the whole commutation step. Only the low-side switch is chopped by an internal free-running PWM counter, which is compared against a duty command.

The controller enters its driving state when the active-low start input is pulled low. When the speed loop asks for deceleration, a brake-style select input sets what happens. With the select high the motor coasts and every switch is off. With the select low the commutation pattern is shifted by half an electrical revolution, so the motor receives reverse torque. An overcurrent trip flag ends the low-side on-time for the rest of the current PWM period. Trips inside a short blanking window at the start of each period are ignored, so that diode recovery spikes cannot cause a cut. A protection shutdown flag holds every low-side switch off.

All inputs are level controls sampled on the clock; none carries a data stream, so there is no valid/ready handshake and no back-pressure. Every input is expected to be synchronous to `clk` already. Each gate output is a register that reflects the inputs sampled at the previous rising edge.

Top module: `bldc_sixstep_ctrl`

## Requirements
- R1: While `rst_n` is low, all six gate enables are 0. After release, the PWM counter starts at count 0 and the trip latch starts cleared.
- R2: In drive, each valid `hall` code {bit2,bit1,bit0} gives one sourcing (high) phase and one sinking (low) phase, with phase k on bit k of `hs_en`/`ls_en`: 001 gives high 0, low 1; 011 gives high 0, low 2; 010 gives high 1, low 2; 110 gives high 1, low 0; 100 gives high 2, low 0; 101 gives high 2, low 1. At most one bit of each output is set, and never in the same phase.
- R3: `hall` codes 000 and 111 switch all six enables off.
- R4: `start_n` high (stop) switches all six enables off. Drive requires `start_n` low.
- R5: During a step, the high-side enable stays on every cycle. The low-side enable is on exactly when the PWM count (0 to PWM_PERIOD-1, advancing by one per clock and wrapping) is below `duty`.
- R6: `duty` 0 keeps the low side off in every cycle. Any `duty` of PWM_PERIOD or more keeps it on in every cycle.
- R7: With `slow_req` high and `brake_n` high (coast), all six enables are off.
- R8: With `slow_req` high and `brake_n` low (reverse torque), the high and low phases of R2 are swapped. The low side is still chopped as in R5.
- R9: If `oc_trip` is high in a cycle where the count is at least BLANK_CYC and below `duty`, the low side is off from the next cycle until the count wraps to 0.
- R10: `oc_trip` in a cycle with the count below BLANK_CYC has no effect.
- R11: `prot_off` high forces every low-side enable off. The high-side enables are unchanged.
- R12: Every output reflects the inputs and PWM count of the previous rising clock edge, which is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall | input | 3 | Rotor sensor phases, bit k high when its positive input exceeds its negative input |
| start_n | input | 1 | Low runs the motor, high stops it |
| brake_n | input | 1 | Deceleration style: low means reverse torque, high means coast |
| slow_req | input | 1 | Deceleration request from the speed loop |
| duty | input | $clog2(PWM_PERIOD+1) | Low-side on-count per PWM period |
| oc_trip | input | 1 | Overcurrent comparator result |
| prot_off | input | 1 | Protection shutdown, holds low sides off |
| hs_en | output | 3 | High-side gate enables, one bit per phase |
| ls_en | output | 3 | Low-side gate enables, one bit per phase |

## Verification
On every cycle, the embedded assertions check these properties:
- no phase has both of its switches on;
- at most one high-side and one low-side enable is set;
- a low-side enable never appears without a high-side partner;
- stop, invalid sensor codes and coasting blank every output on the next cycle;
- protection shutdown and zero duty silence the low side;
- the trip latch holds until the counter wraps and is never set inside the blanking window.

Other behaviour needs the bench's scenarios and its cycle-accurate reference model:
- the exact phase chosen for each sensor code;
- the swapped reverse-torque pattern;
- the position of the chopping edge within the period;
- restoration of the on-time after a trip;
- the one-cycle latency.

// File: rtl/bldc_pkg.sv
package bldc_pkg;
  localparam int NPH = 3;

  typedef logic [NPH-1:0] phase_vec_t;

  typedef struct packed {
    phase_vec_t hi;
    phase_vec_t lo;
  } step_t;
endpackage

// File: rtl/bldc_hall_commutator.sv
module bldc_hall_commutator
  import bldc_pkg::*;
(
  input  logic [NPH-1:0] hall,
  input  logic           reverse,
  output step_t          step,
  output logic           valid
);
  phase_vec_t src;
  phase_vec_t snk;

  // Six-step table: source phase / sink phase per sensor code
  always_comb begin
    unique case (hall)
      3'b001:  begin src = 3'b001; snk = 3'b010; end
      3'b011:  begin src = 3'b001; snk = 3'b100; end
      3'b010:  begin src = 3'b010; snk = 3'b100; end
      3'b110:  begin src = 3'b010; snk = 3'b001; end
      3'b100:  begin src = 3'b100; snk = 3'b001; end
      3'b101:  begin src = 3'b100; snk = 3'b010; end
      default: begin src = 3'b000; snk = 3'b000; end
    endcase
  end

  // Half-revolution shift for reverse torque is a swap of source and sink
  always_comb begin
    valid   = |src;
    step.hi = reverse ? snk : src;
    step.lo = reverse ? src : snk;
  end
endmodule

// File: rtl/bldc_lowside_pwm.sv
module bldc_lowside_pwm #(
  parameter int PWM_PERIOD = 32,
  parameter int BLANK_CYC  = 4,
  localparam int CW        = $clog2(PWM_PERIOD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] duty,
  input  logic          oc_trip,
  output logic          chop
);
  logic [CW-1:0] cnt;
  logic          cut_q;
  logic          wrap;
  logic          raw_on;
  logic          armed;

  always_comb begin
    wrap   = (cnt == CW'(PWM_PERIOD - 1));
    raw_on = (cnt < duty);
    armed  = (cnt >= CW'(BLANK_CYC));
    chop   = raw_on & ~cut_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      cut_q <= 1'b0;
    end else begin
      cnt   <= wrap ? '0 : cnt + 1'b1;
      if (wrap)
        cut_q <= 1'b0;
      else if (oc_trip && armed && raw_on)
        cut_q <= 1'b1;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(PWM_PERIOD)); // R5
  AST_CUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cut_q && !wrap) |=> cut_q); // R9
  AST_CUT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> !cut_q); // R9
  AST_BLANK_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cut_q && cnt < CW'(BLANK_CYC)) |=> !cut_q); // R10
endmodule

// File: rtl/bldc_sixstep_ctrl.sv
module bldc_sixstep_ctrl
  import bldc_pkg::*;
#(
  parameter int PWM_PERIOD = 32,
  parameter int BLANK_CYC  = 4,
  localparam int DW        = $clog2(PWM_PERIOD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    hall,
  input  logic          start_n,
  input  logic          brake_n,
  input  logic          slow_req,
  input  logic [DW-1:0] duty,
  input  logic          oc_trip,
  input  logic          prot_off,
  output logic [2:0]    hs_en,
  output logic [2:0]    ls_en
);
  step_t      step;
  logic       valid;
  logic       chop;
  logic       drive;
  phase_vec_t hs_q;
  phase_vec_t ls_q;

  bldc_hall_commutator u_comm (
    .hall    (hall),
    .reverse (slow_req),
    .step    (step),
    .valid   (valid)
  );

  bldc_lowside_pwm #(
    .PWM_PERIOD (PWM_PERIOD),
    .BLANK_CYC  (BLANK_CYC)
  ) u_pwm (
    .clk     (clk),
    .rst_n   (rst_n),
    .duty    (duty),
    .oc_trip (oc_trip),
    .chop    (chop)
  );

  always_comb drive = ~start_n & valid & ~(slow_req & brake_n);

  for (genvar g = 0; g < NPH; g++) begin : g_phase
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hs_q[g] <= 1'b0;
        ls_q[g] <= 1'b0;
      end else begin
        hs_q[g] <= drive & step.hi[g];
        ls_q[g] <= drive & step.lo[g] & chop & ~prot_off;
      end
    end
  end

  assign hs_en = hs_q;
  assign ls_en = ls_q;

  AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_en & ls_en) == 3'b000); // R2
  AST_HI_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hs_en)); // R2
  AST_LO_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ls_en)); // R2
  AST_LOW_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_en != 3'b000) |-> (hs_en != 3'b000)); // R5
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_n |=> (hs_en == 3'b000 && ls_en == 3'b000)); // R4
  AST_BAD_HALL: assert property (@(posedge clk) disable iff (!rst_n)
    (hall == 3'b000 || hall == 3'b111) |=> (hs_en == 3'b000 && ls_en == 3'b000)); // R3
  AST_COAST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_req && brake_n) |=> (hs_en == 3'b000 && ls_en == 3'b000)); // R7
  AST_PROT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    prot_off |=> (ls_en == 3'b000)); // R11
  AST_DUTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == '0) |=> (ls_en == 3'b000)); // R6
endmodule

// File: tb/bldc_sixstep_ctrl_test.sv
module bldc_sixstep_ctrl_test;
  localparam int P  = 32;
  localparam int B  = 4;
  localparam int DW = $clog2(P + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    hall = 3'b000;
  logic          start_n = 1'b1;
  logic          brake_n = 1'b1;
  logic          slow_req = 1'b0;
  logic [DW-1:0] duty = '0;
  logic          oc_trip = 1'b0;
  logic          prot_off = 1'b0;
  logic [2:0]    hs_en;
  logic [2:0]    ls_en;

  int    tests = 0;
  int    fails = 0;
  string cur_req = "R1";
  int    m_cnt = 0;
  bit    m_cut = 0;
  logic [2:0] exp_hi = 3'b000;
  logic [2:0] exp_lo = 3'b000;

  bldc_sixstep_ctrl #(.PWM_PERIOD(P), .BLANK_CYC(B)) uut (
    .clk(clk), .rst_n(rst_n), .hall(hall), .start_n(start_n),
    .brake_n(brake_n), .slow_req(slow_req), .duty(duty),
    .oc_trip(oc_trip), .prot_off(prot_off), .hs_en(hs_en), .ls_en(ls_en)
  );

  always #5 clk = ~clk;

  // Sensor code to source/sink phase index (R2); -1 means invalid (R3)
  function automatic void ref_map(input logic [2:0] h, output int src, output int snk);
    case (h)
      3'b001: begin src = 0; snk = 1; end
      3'b011: begin src = 0; snk = 2; end
      3'b010: begin src = 1; snk = 2; end
      3'b110: begin src = 1; snk = 0; end
      3'b100: begin src = 2; snk = 0; end
      3'b101: begin src = 2; snk = 1; end
      default: begin src = -1; snk = -1; end
    endcase
  endfunction

  // Behavioural reference model, updated at each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_cut = 0; exp_hi = 3'b000; exp_lo = 3'b000;
    end else begin
      int  s, k, t;
      bit  on;
      ref_map(hall, s, k);
      on = (m_cnt < int'(duty)) && !m_cut;
      if (!start_n && s >= 0 && !(slow_req && brake_n)) begin
        if (slow_req) begin t = s; s = k; k = t; end
        exp_hi = 3'(1 << s);
        exp_lo = (on && !prot_off) ? 3'(1 << k) : 3'b000;
      end else begin
        exp_hi = 3'b000; exp_lo = 3'b000;
      end
      if (m_cnt == P - 1) m_cut = 0;
      else if (oc_trip && m_cnt >= B && m_cnt < int'(duty)) m_cut = 1;
      m_cnt = (m_cnt == P - 1) ? 0 : m_cnt + 1;
    end
  end

  task automatic compare();
    tests++;
    if (hs_en !== exp_hi || ls_en !== exp_lo) begin
      fails++;
      $display("FAIL %s: hs_en=%b ls_en=%b expected hs_en=%b ls_en=%b",
               cur_req, hs_en, ls_en, exp_hi, exp_lo);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run still active, expected finish before 200000 cycles");
    finish_run();
  end

  initial begin
    logic [2:0] seq [6] = '{3'b001, 3'b011, 3'b010, 3'b110, 3'b100, 3'b101};
    // R1 reset state
    cur_req = "R1"; hall = 3'b001; start_n = 1'b0; duty = DW'(P);
    tick(4);
    rst_n = 1'b1;
    // R4 stopped with valid sensors
    cur_req = "R4"; start_n = 1'b1;
    tick(12);
    start_n = 1'b0; duty = DW'(16);
    // R2 full forward walk
    cur_req = "R2";
    for (int i = 0; i < 6; i++) begin hall = seq[i]; tick(40); end
    // R5 chopping edge position across periods
    cur_req = "R5"; duty = DW'(10); hall = 3'b011;
    tick(2 * P);
    // R12 fast sensor changes, one cycle apart
    cur_req = "R12";
    for (int i = 0; i < 12; i++) begin hall = seq[i % 6]; tick(1); end
    // R3 invalid codes
    cur_req = "R3";
    hall = 3'b000; tick(10); hall = 3'b111; tick(10); hall = 3'b010; tick(3);
    // R6 duty extremes
    cur_req = "R6";
    duty = '0; tick(P + 3);
    duty = DW'(P); tick(P + 3);
    duty = DW'(P + 7); tick(P + 3);
    // R7 coast
    cur_req = "R7"; duty = DW'(20); slow_req = 1'b1; brake_n = 1'b1;
    tick(P);
    // R8 reverse torque over all steps
    cur_req = "R8"; brake_n = 1'b0;
    for (int i = 0; i < 6; i++) begin hall = seq[i]; tick(P); end
    slow_req = 1'b0; brake_n = 1'b1; hall = 3'b001;
    // R9 trip after blanking, full duty
    cur_req = "R9"; duty = DW'(P);
    while (m_cnt != 10) tick(1);
    oc_trip = 1'b1; tick(1); oc_trip = 1'b0;
    tick(2 * P);
    duty = DW'(24);
    while (m_cnt != B + 2) tick(1);
    oc_trip = 1'b1; tick(3); oc_trip = 1'b0;
    tick(P);
    // R10 trips only inside the blanking window
    cur_req = "R10"; duty = DW'(P);
    for (int i = 0; i < 3 * P; i++) begin
      oc_trip = (m_cnt < B);
      tick(1);
    end
    oc_trip = 1'b0;
    // R11 protection shutdown
    cur_req = "R11";
    prot_off = 1'b1;
    for (int i = 0; i < 6; i++) begin hall = seq[i]; tick(8); end
    prot_off = 1'b0; tick(P);
    finish_run();
  end
endmodule